// File: doc/BRIEF.md
# System Bus Clock Divider Tree

This block turns one fast source clock, the output of a frequency synthesizer, into three rate-related clock-enable streams. The processor enable and the bus enable are divided directly from the source clock. The peripheral enable is divided from the bus enable, so every peripheral pulse lands on a bus pulse. Each divisor comes from a small code field in a 32-bit configuration word. The bus divider also offers the non-power-of-two ratios 5 and 6. An enable is high for one source cycle once every N cycles, and it stays high all the time when N is 1.

The same word also describes the synthesizer: a not-bypass flag, two feedback factors, an input predivider and a power-of-two postscaler. The block decodes these into a ratio, a multiplier over a denominator, that downstream logic can use to work out the synthesizer frequency from the crystal frequency. When the bypass is in force, the ratio is reported as 1/1.

A new word is written with a one-cycle load strobe. It waits in a holding register and is installed only at a cycle where all three dividers wrap together. Because of this, a pulse interval never mixes the old ratio with the new one.

Top module: `clk_tree_div`

## Requirements
- R1: The processor divisor is selected by word bits 27:25. Codes 0, 1, 2, 3 and 4 divide by 1, 2, 4, 8 and 16. Codes 5, 6 and 7 divide by 1.
- R2: The bus divisor is selected by word bits 22:20. Codes 0 to 7 divide by 1, 2, 4, 5, 6, 8, 16 and 32.
- R3: The peripheral divisor is selected by word bits 19:18. Codes 0 to 3 divide by 1, 2, 4 and 8. It counts bus pulses, so `periph_en_o` is high only in cycles where `bus_en_o` is also high.
- R4: An output with divisor N is high for exactly one cycle in every N cycles. With N equal to 1 it is high in every cycle.
- R5: When word bit 23 (not-bypass) is 0, `pll_bypass_o` is 1, and `pll_mul_o` and `pll_den_o` are both 1.
- R6: When bit 23 is 1, `pll_mul_o` = (bits 15:11 + 1) × (bits 10:5 + 1), and `pll_den_o` = (bits 4:0 + 1) × 2^(bits 17:16).
- R7: A loaded word takes effect only at a cycle where the processor and peripheral enables are both high. Old ratios hold until that cycle. Each output's first pulse after it comes exactly its new divisor cycles later.
- R8: After reset and before any word is installed, all three enables are high in every cycle, `pll_bypass_o` is 1, and the ratio reads 1/1.
- R9: If several words are loaded before a common wrap cycle, the last one loaded is the one installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock (synthesizer output) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 32 | Configuration word |
| cfg_load_i | input | 1 | One-cycle strobe that captures `cfg_i` |
| proc_en_o | output | 1 | Processor clock enable |
| bus_en_o | output | 1 | Bus clock enable |
| periph_en_o | output | 1 | Peripheral clock enable |
| pll_bypass_o | output | 1 | Synthesizer bypassed, source equals crystal |
| pll_mul_o | output | 12 | Synthesizer ratio numerator |
| pll_den_o | output | 9 | Synthesizer ratio denominator |

## Verification
Wrong internal state shows up at the ports in a few specific ways. A bad divisor decode or a stuck counter appears as a wrong spacing between pulses, and this is visible within one period of the slowest output, at most 256 cycles. A word installed at the wrong time shows up as a first post-switch pulse that arrives earlier or later than the new divisor. A wrong pending-register priority shows up as the ratio of a word that was superseded. Every divisor combination is swept, and for each one the first pulse after the switch is timed from the common wrap cycle, while the ratio outputs are checked against arithmetic on the fields.

// File: rtl/clk_tree_pkg.sv
`timescale 1ns/1ps
package clk_tree_pkg;
  localparam int CFG_W    = 32;
  localparam int DIV_W    = 6;
  localparam int N_STAGE  = 3;
  localparam int PROC_LSB = 25;
  localparam int BUS_LSB  = 20;
  localparam int PER_LSB  = 18;
  localparam int NBYP_BIT = 23;
  localparam int FB1_LSB  = 11;
  localparam int FB1_W    = 5;
  localparam int FB2_LSB  = 5;
  localparam int FB2_W    = 6;
  localparam int PRE_LSB  = 0;
  localparam int PRE_W    = 5;
  localparam int PS_LSB   = 16;
  localparam int PS_W     = 2;
  localparam int MUL_W    = FB1_W + FB2_W + 1;
  localparam int DEN_W    = PRE_W + 4;

  function automatic logic [DIV_W-1:0] proc_div(input logic [2:0] code);
    return (code < 3'd5) ? DIV_W'(1) << code : DIV_W'(1);
  endfunction

  function automatic logic [DIV_W-1:0] bus_div(input logic [2:0] code);
    case (code)
      3'd0: return DIV_W'(1);
      3'd1: return DIV_W'(2);
      3'd2: return DIV_W'(4);
      3'd3: return DIV_W'(5);
      3'd4: return DIV_W'(6);
      3'd5: return DIV_W'(8);
      3'd6: return DIV_W'(16);
      default: return DIV_W'(32);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] per_div(input logic [1:0] code);
    return DIV_W'(1) << code;
  endfunction
endpackage

// File: rtl/clk_tree_cfg.sv
`timescale 1ns/1ps
module clk_tree_cfg
  import clk_tree_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             load_i,
  input  logic             apply_i,
  output logic [CFG_W-1:0] act_o
);
  logic [CFG_W-1:0] pend_q, act_q;
  logic             pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      act_q    <= '0;
    end else begin
      if (apply_i && pend_v_q) act_q <= pend_q;
      if (load_i) begin
        pend_q   <= cfg_i;
        pend_v_q <= 1'b1;
      end else if (apply_i) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign act_o = act_q;

  // active word only moves on a wrap cycle with something pending
  assert_swap_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> $past(apply_i && pend_v_q));
  // latest load supersedes
  assert_last_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pend_v_q && pend_q == $past(cfg_i)));
endmodule

// File: rtl/clk_tree_stage.sv
`timescale 1ns/1ps
module clk_tree_stage #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             en_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == div_i - DIV_W'(1));
  assign en_o = tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
  end

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_i);
  assert_unit_div_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == DIV_W'(1) && tick_i) |-> en_o);
endmodule

// File: rtl/clk_tree_pll_dec.sv
`timescale 1ns/1ps
module clk_tree_pll_dec
  import clk_tree_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  output logic             bypass_o,
  output logic [MUL_W-1:0] mul_o,
  output logic [DEN_W-1:0] den_o
);
  logic [FB1_W:0] fb1_p;
  logic [FB2_W:0] fb2_p;
  logic [PRE_W:0] pre_p;
  logic [PS_W-1:0] ps;

  assign fb1_p    = {1'b0, cfg_i[FB1_LSB +: FB1_W]} + (FB1_W+1)'(1);
  assign fb2_p    = {1'b0, cfg_i[FB2_LSB +: FB2_W]} + (FB2_W+1)'(1);
  assign pre_p    = {1'b0, cfg_i[PRE_LSB +: PRE_W]} + (PRE_W+1)'(1);
  assign ps       = cfg_i[PS_LSB +: PS_W];
  assign bypass_o = ~cfg_i[NBYP_BIT];

  always_comb begin
    if (bypass_o) begin
      mul_o = MUL_W'(1);
      den_o = DEN_W'(1);
    end else begin
      mul_o = MUL_W'(fb1_p) * MUL_W'(fb2_p);
      den_o = DEN_W'(pre_p) << ps;
    end
  end
endmodule

// File: rtl/clk_tree_div.sv
`timescale 1ns/1ps
module clk_tree_div
  import clk_tree_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg_i,
  input  logic        cfg_load_i,
  output logic        proc_en_o,
  output logic        bus_en_o,
  output logic        periph_en_o,
  output logic        pll_bypass_o,
  output logic [11:0] pll_mul_o,
  output logic [8:0]  pll_den_o
);
  logic [CFG_W-1:0] act;
  logic [N_STAGE-1:0][DIV_W-1:0] div;
  logic [N_STAGE-1:0] tick, en;
  logic wrap_all;

  assign div[0] = proc_div(act[PROC_LSB +: 3]);
  assign div[1] = bus_div(act[BUS_LSB +: 3]);
  assign div[2] = per_div(act[PER_LSB +: 2]);

  // peripheral stage counts bus pulses, the others count source cycles
  assign tick[0] = 1'b1;
  assign tick[1] = 1'b1;
  assign tick[2] = en[1];

  // periph pulse implies bus wrap, so this is the joint wrap of all counters
  assign wrap_all = en[0] && en[2];

  clk_tree_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg_i),
    .load_i  (cfg_load_i),
    .apply_i (wrap_all),
    .act_o   (act)
  );

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    clk_tree_stage #(.DIV_W(DIV_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick[g]),
      .div_i  (div[g]),
      .en_o   (en[g])
    );
  end

  clk_tree_pll_dec u_pll (
    .cfg_i    (act),
    .bypass_o (pll_bypass_o),
    .mul_o    (pll_mul_o),
    .den_o    (pll_den_o)
  );

  assign proc_en_o   = en[0];
  assign bus_en_o    = en[1];
  assign periph_en_o = en[2];

  assert_periph_on_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_en_o |-> bus_en_o);
  assert_bypass_ratio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_bypass_o |-> (pll_mul_o == 12'd1 && pll_den_o == 9'd1));
  assert_ratio_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_mul_o != 12'd0 && pll_den_o != 9'd0));
endmodule

// File: tb/clk_tree_div_tb_top.sv
`timescale 1ns/1ps
module clk_tree_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic        cfg_load = 1'b0;
  logic        proc_en, bus_en, periph_en, bypass;
  logic [11:0] mul;
  logic [8:0]  den;
  int checks = 0, failures = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clk_tree_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .cfg_load_i(cfg_load),
    .proc_en_o(proc_en), .bus_en_o(bus_en), .periph_en_o(periph_en),
    .pll_bypass_o(bypass), .pll_mul_o(mul), .pll_den_o(den)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int e_proc(input int c);
    return (c < 5) ? (1 << c) : 1;
  endfunction
  function automatic int e_bus(input int c);
    case (c)
      0: return 1; 1: return 2; 2: return 4; 3: return 5;
      4: return 6; 5: return 8; 6: return 16; default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mk_word(input int p, input int b, input int q,
      input int f1, input int f2, input int ipd, input int ps, input bit nb);
    logic [31:0] w = '0;
    w[27:25] = 3'(p); w[22:20] = 3'(b); w[19:18] = 2'(q);
    w[15:11] = 5'(f1); w[10:5] = 6'(f2); w[4:0] = 5'(ipd); w[17:16] = 2'(ps);
    w[23] = nb;
    return w;
  endfunction

  // load at a negedge; held through one posedge
  task automatic load(input logic [31:0] w);
    cfg = w; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_wrap();
    for (int k = 0; k < 700; k++) begin
      if (proc_en && periph_en) return;
      @(negedge clk);
    end
    chk("R7 wrap seen", 0, 1);
  endtask

  // at a wrap negedge: time first pulse of each output after the switch
  task automatic time_first(input int ep, input int eb, input int eq, input string tag);
    int fp = 0, fb = 0, fq = 0;
    for (int n = 1; n <= 300 && (fp == 0 || fb == 0 || fq == 0); n++) begin
      @(negedge clk);
      if (proc_en && fp == 0) fp = n;
      if (bus_en && fb == 0) fb = n;
      if (periph_en && fq == 0) fq = n;
      if (periph_en && !bus_en) chk("R3 periph without bus", 0, 1);
    end
    chk({"R1 R7 proc ratio ", tag}, fp, ep);
    chk({"R2 R7 bus ratio ", tag}, fb, eb);
    chk({"R3 R7 periph ratio ", tag}, fq, eq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state: divide by 1 everywhere, bypass
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 R4 reset proc", int'(proc_en), 1);
      chk("R8 R4 reset bus", int'(bus_en), 1);
      chk("R8 R4 reset periph", int'(periph_en), 1);
    end
    chk("R8 reset bypass", int'(bypass), 1);
    chk("R8 reset mul", int'(mul), 1);
    chk("R8 reset den", int'(den), 1);

    // exhaustive sweep of divisor codes, varied synthesizer fields
    for (int i = 0; i < 256; i++) begin
      int p = (i >> 5) & 7, b = (i >> 2) & 7, q = i & 3;
      int f1 = (i * 7) % 32, f2 = (i * 13) % 64, ipd = (i * 5) % 32, ps = i % 4;
      bit nb = bit'(((i >> 0) ^ (i >> 3)) & 1);
      load(mk_word(p, b, q, f1, f2, ipd, ps, nb));
      wait_wrap();
      time_first(e_proc(p), e_bus(b), e_bus(b) * (1 << q), $sformatf("i=%0d", i));
      if (nb) begin
        chk("R6 not bypassed", int'(bypass), 0);
        chk("R6 mul", int'(mul), (f1 + 1) * (f2 + 1));
        chk("R6 den", int'(den), (ipd + 1) * (1 << ps));
      end else begin
        chk("R5 bypassed", int'(bypass), 1);
        chk("R5 mul", int'(mul), 1);
        chk("R5 den", int'(den), 1);
      end
    end

    // slowest joint wrap: proc 16, bus 32, periph 8
    load(mk_word(4, 7, 3, 0, 0, 0, 0, 1'b0));
    wait_wrap();
    time_first(16, 32, 256, "slow");
    // now on a wrap negedge: queue two words back to back
    load(mk_word(0, 0, 0, 0, 0, 0, 0, 1'b0));
    begin
      int np = 0;
      load(mk_word(1, 3, 2, 3, 4, 1, 2, 1'b1));
      // R7: old ratio must persist until the next joint wrap
      for (int k = 0; k < 200; k++) begin
        if (proc_en) np++;
        @(negedge clk);
      end
      chk("R7 old ratio held proc pulses", np, 12);
      chk("R7 old ratio held bypass", int'(bypass), 1);
    end
    wait_wrap();
    time_first(2, 5, 20, "R9");
    chk("R9 last word ratio mul", int'(mul), 4 * 5);
    chk("R9 last word ratio den", int'(den), 2 * 4);

    summary();
    $finish;
  end
endmodule